// File: doc/BRIEF.md
# Fast ECC Error-Type Classifier

This block is the control path of a double-correcting, triple-detecting memory ECC scheme for a 32-bit word. The check bits form two independent single-correct/double-detect sub-codes, here called side A and side B, plus one extra parity bit. The block receives the two sub-code syndromes, the parity syndrome bit and two status flags from the syndrome stage: the odd-weight flag (`sglTpl`) and the unused-syndrome flag (`lb0`). It decides what kind of error the read carries. The decision rests only on the weight (number of ones) of each syndrome and the parity bit, so it never waits for the slow double-bit locator.

Each accepted read yields one registered, one-hot class: no error, ignore (only check bits are hit), correct, or detect (uncorrectable). For a correct outcome it also yields a selector naming the corrector whose data should be returned: the side-A single corrector, the side-B single corrector, or the pipelined double-bit corrector. When the double corrector is chosen, the block stalls. It raises `waitDbl`, accepts no new read, and presents its result only after the double-bit result is signalled through `dblDone`.

Top module: `eccw_classifier`

## Requirements
- R1: After reset, `resValid`=0, `waitDbl`=0, `errClass`=0, `corrSel`=0 and `inReady`=1.
- R2: A read is accepted on a rising edge where `inValid`=1 and `inReady`=1. For an outcome other than double correction, `resValid` is 1 for exactly the following cycle, and `errClass` and `corrSel` show the result from that cycle until the next accepted read. `errClass` is one-hot: bit0 none, bit1 ignore, bit2 correct, bit3 detect. `corrSel` is 01 for side A, 10 for side B, 11 for double, and 00 for any class other than correct.
- R3: If both syndrome weights are 0 and the parity bit is 0, the class is none.
- R4: The class is ignore when the weight pair (A,B) is one of the following: (0,0) with parity 1; (1,0), (0,1), (2,0) or (0,2) with either parity; (1,1) with parity 1; or (2,1) with parity 1.
- R5: A weight pair of (1,1) with parity 0, or of (3,0) or (0,3), is detect.
- R6: A weight pair of (3,3) with `sglTpl`=0 is correct with side A when parity is 1, or when parity is 0 and `lb0`=0. A (3,3) pair with parity 0 and `lb0`=1, or with `sglTpl`=1, is detect.
- R7: Weights (2,3) or (4,3) with parity 0 give correct with side B. Weights (3,2) or (3,4) with parity 1 give correct with side A. The same weight pairs with the other parity value are detect.
- R8: If both weights are in {2,4,6} and parity is 0, the result is correct with the double selector. If both weights are in that set and parity is 1, the result is detect.
- R9: A double-correct read raises `waitDbl` in the cycle after acceptance and keeps `resValid` at 0. `waitDbl` stays high until `dblDone` is sampled at 1. In the next cycle `resValid`=1 and `waitDbl`=0, with the class and selector still showing correct and double.
- R10: While `waitDbl`=1, `inReady`=0, and reads offered on `inValid` are dropped. The class and selector do not change.
- R11: Any input combination not listed in R3 to R8 is detect. Examples are weights (5,3), (1,3) and (0,4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A read's syndromes are present |
| syndA | input | 7 | Side-A sub-code syndrome |
| syndB | input | 8 | Side-B sub-code syndrome |
| parB | input | 1 | Extra parity syndrome bit |
| sglTpl | input | 1 | Odd-weight status flag from the syndrome stage |
| lb0 | input | 1 | Unused-syndrome status flag |
| dblDone | input | 1 | Double-bit corrector result is ready |
| inReady | output | 1 | A read can be accepted |
| resValid | output | 1 | Classification result is presented this cycle |
| waitDbl | output | 1 | Waiting for the double-bit corrector |
| errClass | output | 4 | One-hot error class |
| corrSel | output | 2 | Corrector selector |

## Verification
The assertions assume that `dblDone` has meaning only while `waitDbl` is high, and that reset is applied before the first read. The bench raises `dblDone` only during a stall, and only for a single cycle. Inputs are driven at the falling edge, so every syndrome value is stable around the capturing edge. The bench builds each syndrome from a target weight by setting the low bits, which keeps every weight within the width of its side.

// File: rtl/eccw_pkg.sv
package eccw_pkg;

  localparam logic [3:0] CLS_NONE    = 4'b0001;
  localparam logic [3:0] CLS_IGNORE  = 4'b0010;
  localparam logic [3:0] CLS_CORRECT = 4'b0100;
  localparam logic [3:0] CLS_DETECT  = 4'b1000;

  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_A    = 2'b01;
  localparam logic [1:0] SEL_B    = 2'b10;
  localparam logic [1:0] SEL_DBL  = 2'b11;

  typedef struct packed {
    logic capture;
    logic dblPending;
  } ctrlStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctrlState_e;

endpackage

// File: rtl/eccw_weight.sv
module eccw_weight #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CW-1:0]    count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < WIDTH; i++) begin
      count = count + CW'(vec[i]);
    end
  end

endmodule

// File: rtl/eccw_datapath.sv
module eccw_datapath
  import eccw_pkg::*;
#(
  parameter int SYND_A_W = 7,
  parameter int SYND_B_W = 8,
  localparam int CWA = $clog2(SYND_A_W + 1),
  localparam int CWB = $clog2(SYND_B_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SYND_A_W-1:0] syndA,
  input  logic [SYND_B_W-1:0] syndB,
  input  logic                parB,
  input  logic                sglTpl,
  input  logic                lb0,
  input  ctrlStrobes_t        strobes,
  output logic                propDbl,
  output logic [3:0]          errClass,
  output logic [1:0]          corrSel
);

  logic [CWA-1:0] cntA;
  logic [CWB-1:0] cntB;
  logic [7:0]     wA;
  logic [7:0]     wB;
  logic [8:0]     wSum;
  logic           aEven;
  logic           bEven;
  logic           lowWeight;
  logic [3:0]     propCls;
  logic [1:0]     propSel;

  eccw_weight #(.WIDTH(SYND_A_W)) i_weightA (.vec(syndA), .count(cntA));
  eccw_weight #(.WIDTH(SYND_B_W)) i_weightB (.vec(syndB), .count(cntB));

  assign wA        = 8'(cntA);
  assign wB        = 8'(cntB);
  assign wSum      = 9'(wA) + 9'(wB);
  assign aEven     = (wA == 8'd2) || (wA == 8'd4) || (wA == 8'd6);
  assign bEven     = (wB == 8'd2) || (wB == 8'd4) || (wB == 8'd6);
  assign lowWeight = (wSum <= 9'd2);

  always_comb begin
    propCls = CLS_DETECT;
    propSel = SEL_NONE;
    if (wA == 8'd0 && wB == 8'd0 && !parB) begin
      propCls = CLS_NONE;
    end else if ((lowWeight && !(wA == 8'd1 && wB == 8'd1 && !parB)) ||
                 (wA == 8'd2 && wB == 8'd1 && parB)) begin
      propCls = CLS_IGNORE;
    end else if (wA == 8'd3 && wB == 8'd3 && !sglTpl && (parB || !lb0)) begin
      propCls = CLS_CORRECT;
      propSel = SEL_A;
    end else if ((wA == 8'd2 || wA == 8'd4) && wB == 8'd3 && !parB) begin
      propCls = CLS_CORRECT;
      propSel = SEL_B;
    end else if (wA == 8'd3 && (wB == 8'd2 || wB == 8'd4) && parB) begin
      propCls = CLS_CORRECT;
      propSel = SEL_A;
    end else if (aEven && bEven && !parB) begin
      propCls = CLS_CORRECT;
      propSel = SEL_DBL;
    end
  end

  assign propDbl = (propSel == SEL_DBL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errClass <= '0;
      corrSel  <= SEL_NONE;
    end else if (strobes.capture) begin
      errClass <= propCls;
      corrSel  <= propSel;
    end
  end

  // R2: selector is non-zero exactly for a correct class
  assert_sel_matches_class_R2: assert property (@(posedge clk) disable iff (!rstN)
    (corrSel != SEL_NONE) == (errClass == CLS_CORRECT));

  assert_class_onehot0_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(errClass));

  // R9: while stalled the registered selector names the double corrector
  assert_pending_is_dbl_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dblPending |-> (corrSel == SEL_DBL && errClass == CLS_CORRECT));

  // R10: without a capture strobe the result is held
  assert_hold_without_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(errClass) && $stable(corrSel)));

endmodule

// File: rtl/eccw_control.sv
module eccw_control
  import eccw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         propDbl,
  input  logic         dblDone,
  output ctrlStrobes_t strobes,
  output logic         inReady,
  output logic         waitDbl,
  output logic         resValid
);

  ctrlState_e state;
  ctrlState_e stateNext;
  logic       accept;
  logic       release_;

  assign accept   = (state == ST_IDLE) && inValid;
  assign release_ = (state == ST_WAIT) && dblDone;

  always_comb begin
    stateNext = state;
    if (accept && propDbl) stateNext = ST_WAIT;
    else if (release_)     stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      resValid <= 1'b0;
    end else begin
      state    <= stateNext;
      resValid <= (accept && !propDbl) || release_;
    end
  end

  assign inReady            = (state == ST_IDLE);
  assign waitDbl            = (state == ST_WAIT);
  assign strobes.capture    = accept;
  assign strobes.dblPending = waitDbl;

  // R9: stall persists until the double result is signalled
  assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (waitDbl && !dblDone) |=> (waitDbl && !resValid));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (waitDbl && dblDone) |=> (resValid && !waitDbl));

  // R2: a plain accepted read produces a result next cycle
  assert_plain_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid && !propDbl) |=> resValid);

endmodule

// File: rtl/eccw_classifier.sv
module eccw_classifier
  import eccw_pkg::*;
#(
  parameter int SYND_A_W = 7,
  parameter int SYND_B_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SYND_A_W-1:0] syndA,
  input  logic [SYND_B_W-1:0] syndB,
  input  logic                parB,
  input  logic                sglTpl,
  input  logic                lb0,
  input  logic                dblDone,
  output logic                inReady,
  output logic                resValid,
  output logic                waitDbl,
  output logic [3:0]          errClass,
  output logic [1:0]          corrSel
);

  ctrlStrobes_t strobes;
  logic         propDbl;

  eccw_datapath #(.SYND_A_W(SYND_A_W), .SYND_B_W(SYND_B_W)) i_datapath (
    .clk(clk), .rstN(rstN), .syndA(syndA), .syndB(syndB), .parB(parB),
    .sglTpl(sglTpl), .lb0(lb0), .strobes(strobes), .propDbl(propDbl),
    .errClass(errClass), .corrSel(corrSel)
  );

  eccw_control i_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .propDbl(propDbl),
    .dblDone(dblDone), .strobes(strobes), .inReady(inReady),
    .waitDbl(waitDbl), .resValid(resValid)
  );

  // R2: a presented result always carries exactly one class
  assert_result_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $onehot(errClass));

endmodule

// File: tb/test_eccw_classifier.sv
module test_eccw_classifier;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [6:0] syndA = '0;
  logic [7:0] syndB = '0;
  logic       parB = 1'b0;
  logic       sglTpl = 1'b0;
  logic       lb0 = 1'b0;
  logic       dblDone = 1'b0;
  logic       inReady;
  logic       resValid;
  logic       waitDbl;
  logic [3:0] errClass;
  logic [1:0] corrSel;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  localparam logic [3:0] C_NONE = 4'b0001, C_IGN = 4'b0010, C_COR = 4'b0100, C_DET = 4'b1000;
  localparam logic [1:0] S_NO = 2'b00, S_A = 2'b01, S_B = 2'b10, S_DBL = 2'b11;

  always #5 clk = ~clk;

  eccw_classifier i_eccw_classifier (
    .clk(clk), .rstN(rstN), .inValid(inValid), .syndA(syndA), .syndB(syndB),
    .parB(parB), .sglTpl(sglTpl), .lb0(lb0), .dblDone(dblDone),
    .inReady(inReady), .resValid(resValid), .waitDbl(waitDbl),
    .errClass(errClass), .corrSel(corrSel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ones(input int n);
    logic [7:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  // drives one read at a falling edge, samples at the next falling edge
  task automatic readOnce(input int wa, input int wb, input logic p,
                          input logic s, input logic l);
    logic [7:0] va = ones(wa);
    @(negedge clk);
    syndA = va[6:0]; syndB = ones(wb); parB = p; sglTpl = s; lb0 = l;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectPlain(input string req, input int wa, input int wb, input logic p,
                             input logic s, input logic l,
                             input logic [3:0] cls, input logic [1:0] sel);
    readOnce(wa, wb, p, s, l);
    check({req, " resValid"}, 8'(resValid), 8'd1);
    check({req, " class"}, 8'(errClass), 8'(cls));
    check({req, " sel"}, 8'(corrSel), 8'(sel));
  endtask

  task automatic testReset();
    check("R1 resValid", 8'(resValid), 8'd0);
    check("R1 waitDbl", 8'(waitDbl), 8'd0);
    check("R1 class", 8'(errClass), 8'd0);
    check("R1 sel", 8'(corrSel), 8'd0);
    check("R1 inReady", 8'(inReady), 8'd1);
  endtask

  task automatic testNone();
    expectPlain("R3", 0, 0, 0, 0, 0, C_NONE, S_NO);
    @(negedge clk);
    check("R2 single-cycle valid", 8'(resValid), 8'd0);
    check("R2 class held", 8'(errClass), 8'(C_NONE));
  endtask

  task automatic testIgnore();
    expectPlain("R4 par only", 0, 0, 1, 0, 0, C_IGN, S_NO);
    expectPlain("R4 1/0 p0", 1, 0, 0, 0, 0, C_IGN, S_NO);
    expectPlain("R4 0/1 p1", 0, 1, 1, 0, 0, C_IGN, S_NO);
    expectPlain("R4 2/0 p1", 2, 0, 1, 0, 0, C_IGN, S_NO);
    expectPlain("R4 0/2 p0", 0, 2, 0, 0, 0, C_IGN, S_NO);
    expectPlain("R4 1/1 p1", 1, 1, 1, 0, 0, C_IGN, S_NO);
    expectPlain("R4 2/1 p1", 2, 1, 1, 0, 0, C_IGN, S_NO);
  endtask

  task automatic testLowDetect();
    expectPlain("R5 1/1 p0", 1, 1, 0, 0, 0, C_DET, S_NO);
    expectPlain("R5 3/0", 3, 0, 0, 0, 0, C_DET, S_NO);
    expectPlain("R5 0/3", 0, 3, 1, 0, 0, C_DET, S_NO);
  endtask

  task automatic testSingle();
    expectPlain("R6 3/3 p0", 3, 3, 0, 0, 0, C_COR, S_A);
    expectPlain("R6 3/3 p1 lb1", 3, 3, 1, 0, 1, C_COR, S_A);
    expectPlain("R6 3/3 lb1", 3, 3, 0, 0, 1, C_DET, S_NO);
    expectPlain("R6 3/3 tpl", 3, 3, 0, 1, 1, C_DET, S_NO);
  endtask

  task automatic testSide();
    expectPlain("R7 2/3 p0", 2, 3, 0, 0, 0, C_COR, S_B);
    expectPlain("R7 4/3 p0", 4, 3, 0, 0, 0, C_COR, S_B);
    expectPlain("R7 3/2 p1", 3, 2, 1, 0, 0, C_COR, S_A);
    expectPlain("R7 3/4 p1", 3, 4, 1, 0, 0, C_COR, S_A);
    expectPlain("R7 2/3 p1", 2, 3, 1, 0, 0, C_DET, S_NO);
    expectPlain("R7 3/4 p0", 3, 4, 0, 0, 0, C_DET, S_NO);
  endtask

  task automatic testDouble();
    expectPlain("R8 4/6 p1", 4, 6, 1, 0, 0, C_DET, S_NO);
    readOnce(2, 4, 0, 0, 0);
    check("R9 waitDbl", 8'(waitDbl), 8'd1);
    check("R9 no result", 8'(resValid), 8'd0);
    check("R8 class", 8'(errClass), 8'(C_COR));
    check("R8 sel", 8'(corrSel), 8'(S_DBL));
    check("R10 inReady", 8'(inReady), 8'd0);
    readOnce(1, 0, 0, 0, 0);
    readOnce(0, 0, 0, 0, 0);
    check("R10 read dropped class", 8'(errClass), 8'(C_COR));
    check("R10 read dropped sel", 8'(corrSel), 8'(S_DBL));
    check("R9 still waiting", 8'(waitDbl), 8'd1);
    check("R9 still no result", 8'(resValid), 8'd0);
    dblDone = 1'b1;
    @(negedge clk);
    dblDone = 1'b0;
    check("R9 result", 8'(resValid), 8'd1);
    check("R9 released", 8'(waitDbl), 8'd0);
    check("R9 sel kept", 8'(corrSel), 8'(S_DBL));
    check("R9 inReady back", 8'(inReady), 8'd1);
    @(negedge clk);
    check("R9 one-cycle result", 8'(resValid), 8'd0);
    readOnce(6, 6, 0, 0, 0);
    check("R8 6/6 sel", 8'(corrSel), 8'(S_DBL));
    dblDone = 1'b1;
    @(negedge clk);
    dblDone = 1'b0;
  endtask

  task automatic testFallthrough();
    expectPlain("R11 5/3", 5, 3, 0, 0, 0, C_DET, S_NO);
    expectPlain("R11 1/3", 1, 3, 0, 0, 0, C_DET, S_NO);
    expectPlain("R11 0/4", 0, 4, 1, 0, 0, C_DET, S_NO);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNone();
    testIgnore();
    testLowDetect();
    testSingle();
    testSide();
    testDouble();
    testFallthrough();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule